// File: doc/BRIEF.md
# Event-Selectable Performance Counter with Address Sampling

This block is one 32-bit performance counter. A six-bit select code, held in a control register, picks which pipeline event pulse the counter adds up. Each event arrives as a one-cycle pulse on its own input bit. Alongside the pulses, the pipeline supplies the effective address of the instruction responsible for the event in the current cycle.

When an increment moves the counter's top bit from 0 to 1, the counter has turned negative. At that point the block sets a pending interrupt flag and captures that cycle's instruction address into a sampled-address register. The captured address stays frozen until software clears the flag.

Software reaches the counter, the control register and the sampled address through a small register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `perfCounter`

## Requirements
- R1: After reset the counter, select code, pending flag, sampled address and `irq` are all zero.
- R2: Select code 0, and every code from 21 to 63, counts nothing: the counter holds its value whatever pulses arrive.
- R3: A select code c in 1..20 adds one to the counter on each clock edge where `evtVec[c-1]` is high, and ignores all other event bits. The code meanings are:
  - 1: cycles
  - 2: completed instructions
  - 4: dispatched instructions
  - 6: data cache misses
  - 7: instruction cache misses
  - 8: completed branches
  - 9: successful store-conditionals
  - 16: branch unit dispatches
  - 17: single-cycle integer unit dispatches
  - 18: completed loads
  - 19: multi-cycle integer unit dispatches
  - 20: snoop hits
- R4: The counter wraps from 0xFFFFFFFF to 0 without raising the interrupt.
- R5: An increment from 0x7FFFFFFF to 0x80000000 sets the pending flag, and `irq` is high from that same edge.
- R6: On that crossing edge, the sampled-address register takes the `evtAddr` value present in the crossing cycle.
- R7: While the flag is pending, the sampled address does not change, even if a later increment crosses into negative again.
- R8: A software write to the counter loads `regWrData` and never raises the interrupt, even when bit 31 of the written value is set.
- R9: A counter write in the same cycle as a counted event wins: the counter takes the written value and does not increment.
- R10: The control register is at `regSel`=1. Bits [5:0] are the select code and bit 31 reads back the pending flag. Writing bit 31 as 0 clears the flag; writing it as 1 leaves the flag unchanged.
- R11: `regRdData` shows the counter for `regSel`=0, the control register for 1, the sampled address for 2, and zero for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtVec | input | 20 | Event pulses; bit c-1 belongs to select code c |
| evtAddr | input | 32 | Effective address of the instruction behind this cycle's event |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 counter, 1 control, 2 sampled address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational |
| irq | output | 1 | Monitor interrupt, equal to the pending flag |

## Verification
The hardest situation to reach is the sign crossing itself. Counting to 2^31 is out of reach, so the stimulus preloads the counter to just below 0x80000000 through the register port. It then pulses the chosen event with a distinct address in each cycle, which shows that exactly the crossing cycle's address is kept. A second crossing while the flag is still pending is set up the same way, by rewriting the counter. Each step is followed by reading back the sampled address to show it stayed frozen.

// File: rtl/perfPkg.sv
package perfPkg;
  localparam logic [1:0] REG_CNT  = 2'd0;
  localparam logic [1:0] REG_CTL  = 2'd1;
  localparam logic [1:0] REG_SAMP = 2'd2;

  typedef struct packed {
    logic incr;
    logic wrCnt;
    logic wrCtl;
    logic setPend;
    logic clrPend;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/perfCtrl.sv
module perfCtrl
  import perfPkg::*;
#(
  parameter int SEL_W   = 6,
  parameter int NUM_EVT = 20
) (
  input  logic [SEL_W-1:0]   selCode,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic               cntAtEdge,
  input  logic               pendQ,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic               wrPendBit,
  output dpStrobe_t          strb
);
  logic eventHit;
  logic crossing;

  // Select code c maps to event bit c-1; any other code matches nothing.
  always_comb begin
    eventHit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (selCode == SEL_W'(i + 1)) eventHit = evtVec[i];
    end
  end

  always_comb begin
    strb.wrCnt   = regWrEn && (regSel == REG_CNT);
    strb.wrCtl   = regWrEn && (regSel == REG_CTL);
    strb.incr    = eventHit && !strb.wrCnt;
    crossing     = strb.incr && cntAtEdge;
    strb.setPend = crossing;
    strb.clrPend = strb.wrCtl && !wrPendBit;
    strb.capture = crossing && (!pendQ || strb.clrPend);
  end
endmodule

// File: rtl/perfDatapath.sv
module perfDatapath
  import perfPkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] evtAddr,
  input  logic [1:0]        regSel,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic [CNT_W-1:0]  cntQ,
  output logic [SEL_W-1:0]  selQ,
  output logic              pendQ,
  output logic [ADDR_W-1:0] sampQ,
  output logic              cntAtEdge
);
  localparam logic [CNT_W-1:0] EDGE_VAL = {1'b0, {(CNT_W-1){1'b1}}};
  localparam int PAD_W = CNT_W - 1 - SEL_W;

  assign cntAtEdge = (cntQ == EDGE_VAL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      selQ  <= '0;
      pendQ <= 1'b0;
      sampQ <= '0;
    end else begin
      if (strb.wrCnt)     cntQ <= regWrData;
      else if (strb.incr) cntQ <= cntQ + 1'b1;

      if (strb.wrCtl) selQ <= regWrData[SEL_W-1:0];

      if (strb.setPend)      pendQ <= 1'b1;
      else if (strb.clrPend) pendQ <= 1'b0;

      if (strb.capture) sampQ <= evtAddr;
    end
  end

  always_comb begin
    case (regSel)
      REG_CNT:  regRdData = cntQ;
      REG_CTL:  regRdData = {pendQ, {PAD_W{1'b0}}, selQ};
      REG_SAMP: regRdData = CNT_W'(sampQ);
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/perfCounter.sv
module perfCounter
  import perfPkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 6,
  parameter int NUM_EVT = 20,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic [ADDR_W-1:0]  evtAddr,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [CNT_W-1:0]   regWrData,
  output logic [CNT_W-1:0]   regRdData,
  output logic               irq
);
  dpStrobe_t         strb;
  logic [CNT_W-1:0]  cntVal;
  logic [SEL_W-1:0]  selVal;
  logic              pendVal;
  logic [ADDR_W-1:0] sampVal;
  logic              cntAtEdge;

  perfCtrl #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) ctrl (
    .selCode   (selVal),
    .evtVec    (evtVec),
    .cntAtEdge (cntAtEdge),
    .pendQ     (pendVal),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .wrPendBit (regWrData[CNT_W-1]),
    .strb      (strb)
  );

  perfDatapath #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evtAddr   (evtAddr),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cntQ      (cntVal),
    .selQ      (selVal),
    .pendQ     (pendVal),
    .sampQ     (sampVal),
    .cntAtEdge (cntAtEdge)
  );

  assign irq = pendVal;
endmodule

// File: rtl/perfCounterChecker.sv
module perfCounterChecker #(
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 6,
  parameter int NUM_EVT = 20,
  parameter int ADDR_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regSel,
  input logic [CNT_W-1:0]  regWrData,
  input logic              irq,
  input logic [CNT_W-1:0]  cntVal,
  input logic [SEL_W-1:0]  selVal,
  input logic [ADDR_W-1:0] sampVal
);
  localparam logic [CNT_W-1:0] NEG_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] POS_MAX = {1'b0, {(CNT_W-1){1'b1}}};

  logic cntWr, ctlWr, idleSel;
  assign cntWr   = regWrEn && (regSel == 2'd0);
  assign ctlWr   = regWrEn && (regSel == 2'd1);
  assign idleSel = (selVal == '0) || (selVal > SEL_W'(NUM_EVT));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idleSel && !cntWr) |=> $stable(cntVal));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cntWr) |-> (cntVal == $past(cntVal) || cntVal == CNT_W'($past(cntVal) + 1'b1)));

  assert_irq_on_cross_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (cntVal == NEG_MIN && $past(cntVal) == POS_MAX));

  assert_sample_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ctlWr) |=> $stable(sampVal));

  assert_write_no_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && cntWr) |=> !irq);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWr) |-> (cntVal == $past(regWrData)));
endmodule

bind perfCounter perfCounterChecker #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .irq       (irq),
  .cntVal    (cntVal),
  .selVal    (selVal),
  .sampVal   (sampVal)
);

// File: tb/perfCounter_test.sv
`timescale 1ns/1ps
module perfCounter_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [19:0] evtVec;
  logic [31:0] evtAddr;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  perfCounter uut (
    .clk(clk), .rstN(rstN), .evtVec(evtVec), .evtAddr(evtAddr),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive at the falling edge, release just after the rising edge.
  task automatic step(input logic [19:0] ev, input logic [31:0] addr,
                      input logic we, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    evtVec = ev; evtAddr = addr; regWrEn = we; regSel = sel; regWrData = d;
    @(posedge clk);
    #1;
    evtVec = '0; regWrEn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    step('0, '0, 1'b1, sel, d);
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    regSel = sel;
    #0.1;
    v = regRdData;
  endtask

  task automatic testReset;
    logic [31:0] v;
    rd(2'd0, v); check("R1 counter", v, 32'h0);
    rd(2'd1, v); check("R1 control", v, 32'h0);
    rd(2'd2, v); check("R1 sample", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic testIdleCodes;
    logic [31:0] v;
    wr(2'd0, 32'h55);
    wr(2'd1, 32'h0);
    for (int k = 0; k < 4; k++) step('1, 32'h100, 1'b0, 2'd0, '0);
    rd(2'd0, v); check("R2 code 0 holds", v, 32'h55);
    wr(2'd1, 32'd21);
    for (int k = 0; k < 3; k++) step('1, 32'h100, 1'b0, 2'd0, '0);
    rd(2'd0, v); check("R2 code 21 holds", v, 32'h55);
    wr(2'd1, 32'd63);
    for (int k = 0; k < 3; k++) step('1, 32'h100, 1'b0, 2'd0, '0);
    rd(2'd0, v); check("R2 code 63 holds", v, 32'h55);
  endtask

  task automatic testCodes;
    int codes[12] = '{1, 2, 4, 6, 7, 8, 9, 16, 17, 18, 19, 20};
    logic [31:0] v;
    foreach (codes[j]) begin
      logic [19:0] mine;
      mine = 20'b1 << (codes[j] - 1);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'(codes[j]));
      for (int k = 0; k < 3; k++) step(mine, 32'h0, 1'b0, 2'd0, '0);
      for (int k = 0; k < 2; k++) step(~mine, 32'h0, 1'b0, 2'd0, '0);
      step('0, 32'h0, 1'b0, 2'd0, '0);
      rd(2'd0, v);
      check($sformatf("R3 code %0d counts own bit only", codes[j]), v, 32'd3);
    end
    rd(2'd1, v); check("R10 control readback", v, 32'd20);
  endtask

  task automatic testWrap;
    logic [31:0] v;
    wr(2'd1, 32'd1);
    wr(2'd0, 32'hFFFF_FFFF);
    step(20'h1, 32'h0, 1'b0, 2'd0, '0);
    rd(2'd0, v); check("R4 wraps to zero", v, 32'h0);
    check("R4 no irq on wrap", {31'b0, irq}, 32'h0);
  endtask

  task automatic testCrossing;
    logic [31:0] v;
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h7FFF_FFFE);
    step(20'h2, 32'hA000_0001, 1'b0, 2'd0, '0);
    check("R5 no irq before crossing", {31'b0, irq}, 32'h0);
    step(20'h2, 32'hA000_0002, 1'b0, 2'd0, '0);
    check("R5 irq at crossing", {31'b0, irq}, 32'h1);
    rd(2'd0, v); check("R5 counter negative", v, 32'h8000_0000);
    rd(2'd2, v); check("R6 sampled crossing address", v, 32'hA000_0002);
    rd(2'd1, v); check("R10 pending bit visible", v, 32'h8000_0002);
  endtask

  task automatic testFrozen;
    logic [31:0] v;
    for (int k = 0; k < 3; k++) step(20'h2, 32'hB000_0000 + 32'(k), 1'b0, 2'd0, '0);
    wr(2'd0, 32'h7FFF_FFFF);
    step(20'h2, 32'hC000_0004, 1'b0, 2'd0, '0);
    rd(2'd0, v); check("R7 second crossing counted", v, 32'h8000_0000);
    rd(2'd2, v); check("R7 sample frozen", v, 32'hA000_0002);
    wr(2'd1, 32'h8000_0002);
    check("R10 writing one keeps pending", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h0000_0002);
    check("R10 writing zero clears", {31'b0, irq}, 32'h0);
    rd(2'd2, v); check("R7 sample kept after clear", v, 32'hA000_0002);
  endtask

  task automatic testSoftWrite;
    logic [31:0] v;
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h8000_0005);
    check("R8 write with bit31 no irq", {31'b0, irq}, 32'h0);
    rd(2'd0, v); check("R8 written value", v, 32'h8000_0005);
    wr(2'd1, 32'd1);
    step(20'h1, 32'hD000_0000, 1'b1, 2'd0, 32'h10);
    rd(2'd0, v); check("R9 write beats increment", v, 32'h10);
    step(20'h1, 32'hD000_0001, 1'b1, 2'd0, 32'h7FFF_FFFF);
    rd(2'd0, v); check("R9 write at edge value", v, 32'h7FFF_FFFF);
    check("R9 no crossing from write", {31'b0, irq}, 32'h0);
    rd(2'd3, v); check("R11 unused select reads zero", v, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; evtVec = '0; evtAddr = '0; regWrEn = 1'b0; regSel = '0; regWrData = '0;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testIdleCodes();
    testCodes();
    testWrap();
    testCrossing();
    testFrozen();
    testSoftWrite();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule